// File: doc/BRIEF.md
# Register-Resident Receive Descriptor Ring

This block holds a small ring of receive descriptors as flip-flops rather than as structures in memory. Each slot pairs a buffer word with a frame status word. Software arms a slot by writing a 64-byte aligned buffer address with the enable bit set. The receive engine uses the slots strictly in ring order. When a frame ends, the block records the length and error flags in the status word of the current slot. It marks that slot done, disarms it and moves on to the next slot.

The receive engine reports each frame end on a valid/ready stream that carries the length and the flag bits. The ring reports the current slot's buffer address and armed state so that the engine knows where to place bytes. Every buffer word also shows the hardware's current slot index, so that software can find where the ring stands after a reset. A level interrupt signals slots that wait for service.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every register reads zero: each slot is disarmed and not done, the buffer address is zero, the status is zero, the current index is 0, irq is low and fe_ready is high. A reset later in operation clears the same state.
- R2: A buffer word reads with bit 0 = enable, bit 1 = done, bits 3:2 = the current hardware index, bits 5:4 = 0, and bits 31:6 = the buffer address.
- R3: A write to a buffer word loads bits 31:6 as the address and bit 0 as enable. When bit 0 is 1 the write also clears done. Written bits 5:1 are ignored.
- R4: Status words are read-only, and writes to them have no effect.
- R5: A frame end accepted while the current slot is armed does all of the following at one clock edge. It writes status bits 13:0 with the length, and status bit 14+k with fe_flags[k]. It sets done, clears enable and advances the index by one.
- R6: The index wraps from NUM_DESC-1 back to 0.
- R7: A frame end accepted while the current slot is disarmed is dropped, and no slot and no index changes. The next status that is written has bit 31 (missed frame) set, and the status written after that has it only if fe_flags[17] is set.
- R8: irq is high exactly while some slot has done set and enable clear.
- R9: fe_ready is low in a cycle where software writes the current slot's buffer word. The frame end is then held and is not taken.
- R10: cur_buf and cur_armed show the address and enable of the slot at cur_idx.

Register address: bits [IDX_W:1] select the slot, and bit 0 selects the buffer word (0) or the status word (1). Within the flags, the error bits are watchdog 14, runt 15, overlength 16, collision 17, MII error 19, CRC 21, length error 24, unknown control 26 and missed 31. The information bits are frame type 18, dribble 20, first tag 22, second tag 23, control 25, multicast 27, broadcast 28, filter fail 29 and packet filter 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | IDX_W+1 | Write address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | IDX_W+1 | Read address |
| reg_rd_data | output | 32 | Combinational read data |
| fe_valid | input | 1 | Frame end present |
| fe_ready | output | 1 | Frame end can be taken |
| fe_len | input | 14 | Frame length including FCS |
| fe_flags | input | 18 | Flags for status bits 31:14 |
| cur_idx | output | IDX_W | Current slot index |
| cur_buf | output | 26 | Buffer address of the current slot |
| cur_armed | output | 1 | Current slot enabled |
| irq | output | 1 | Slot-done interrupt level |

## Verification
The assertions assume that the engine holds fe_valid and its payload stable until fe_ready is seen high, and that write addresses always name an existing slot. The directed stimulus changes inputs only at falling edges and keeps fe_valid asserted through a stalled cycle. It uses slot addresses only below NUM_DESC, so the checked advance, hold and arm properties see only legal traffic.

// File: rtl/rxring_pkg.sv
`timescale 1ns/1ps
package rxring_pkg;
  localparam int RXR_DW      = 32;
  localparam int RXR_LEN_W   = 14;
  localparam int RXR_FLAG_W  = RXR_DW - RXR_LEN_W;
  localparam int RXR_ALIGN   = 6;
  localparam int RXR_ABUF_W  = RXR_DW - RXR_ALIGN;
  localparam int RXR_IDXF_W  = 2;
  localparam int RXR_MISS_K  = RXR_FLAG_W - 1;
endpackage

// File: rtl/rxring_entry.sv
`timescale 1ns/1ps
module rxring_entry
  import rxring_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_we,
  input  logic [RXR_ABUF_W-1:0] sw_addr,
  input  logic                  sw_en,
  input  logic                  hw_fill,
  input  logic [RXR_DW-1:0]     hw_status,
  output logic                  en,
  output logic                  done,
  output logic [RXR_ABUF_W-1:0] baddr,
  output logic [RXR_DW-1:0]     status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      done   <= 1'b0;
      baddr  <= '0;
      status <= '0;
    end else if (hw_fill) begin
      status <= hw_status;
      done   <= 1'b1;
      en     <= 1'b0;
    end else if (sw_we) begin
      baddr <= sw_addr;
      en    <= sw_en;
      if (sw_en) done <= 1'b0;
    end
  end
endmodule

// File: rtl/rxring_seq.sv
`timescale 1ns/1ps
module rxring_seq
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fe_valid,
  input  logic [RXR_LEN_W-1:0]  fe_len,
  input  logic [RXR_FLAG_W-1:0] fe_flags,
  input  logic                  blocked,
  input  logic                  cur_armed,
  output logic                  fe_ready,
  output logic                  fill,
  output logic [IDX_W-1:0]      cur_idx,
  output logic [RXR_DW-1:0]     status_word
);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);

  logic miss_pend;
  logic accept;
  logic [RXR_FLAG_W-1:0] flags_m;

  assign fe_ready = !blocked;
  assign accept   = fe_valid && fe_ready;
  assign fill     = accept && cur_armed;

  always_comb begin
    flags_m = fe_flags;
    flags_m[RXR_MISS_K] = fe_flags[RXR_MISS_K] | miss_pend;
  end
  assign status_word = {flags_m, fe_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      miss_pend <= 1'b0;
    end else if (accept) begin
      if (cur_armed) begin
        cur_idx   <= (cur_idx == LAST) ? '0 : cur_idx + STEP;
        miss_pend <= 1'b0;
      end else begin
        miss_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxring_regif.sv
`timescale 1ns/1ps
module rxring_regif
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int RA_W  = IDX_W + 1
) (
  input  logic                                 reg_wr_en,
  input  logic [RA_W-1:0]                      reg_wr_addr,
  input  logic [RA_W-1:0]                      reg_rd_addr,
  input  logic [NUM_DESC-1:0]                  en_v,
  input  logic [NUM_DESC-1:0]                  done_v,
  input  logic [NUM_DESC-1:0][RXR_ABUF_W-1:0]  baddr_v,
  input  logic [NUM_DESC-1:0][RXR_DW-1:0]      status_v,
  input  logic [IDX_W-1:0]                     cur_idx,
  output logic [NUM_DESC-1:0]                  buf_we,
  output logic [RXR_DW-1:0]                    reg_rd_data
);
  logic [NUM_DESC-1:0][RXR_DW-1:0] bufw_v;
  logic [RXR_IDXF_W-1:0] idx_field;
  logic [IDX_W-1:0] rd_sel;

  assign idx_field = RXR_IDXF_W'(cur_idx);
  assign rd_sel    = reg_rd_addr[RA_W-1:1];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_slot
    assign buf_we[i] = reg_wr_en && !reg_wr_addr[0] &&
                       (reg_wr_addr[RA_W-1:1] == IDX_W'(i));
    assign bufw_v[i] = {baddr_v[i], 2'b00, idx_field, done_v[i], en_v[i]};
  end

  always_comb begin
    reg_rd_data = '0;
    if (int'(rd_sel) < NUM_DESC)
      reg_rd_data = reg_rd_addr[0] ? status_v[rd_sel] : bufw_v[rd_sel];
  end
endmodule

// File: rtl/rx_desc_ring.sv
`timescale 1ns/1ps
module rx_desc_ring
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int RA_W  = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [RA_W-1:0]       reg_wr_addr,
  input  logic [RXR_DW-1:0]     reg_wr_data,
  input  logic [RA_W-1:0]       reg_rd_addr,
  output logic [RXR_DW-1:0]     reg_rd_data,
  input  logic                  fe_valid,
  output logic                  fe_ready,
  input  logic [RXR_LEN_W-1:0]  fe_len,
  input  logic [RXR_FLAG_W-1:0] fe_flags,
  output logic [IDX_W-1:0]      cur_idx,
  output logic [RXR_ABUF_W-1:0] cur_buf,
  output logic                  cur_armed,
  output logic                  irq
);
  logic [NUM_DESC-1:0]                 ent_en;
  logic [NUM_DESC-1:0]                 ent_done;
  logic [NUM_DESC-1:0][RXR_ABUF_W-1:0] ent_baddr;
  logic [NUM_DESC-1:0][RXR_DW-1:0]     ent_status;
  logic [NUM_DESC-1:0]                 buf_we;
  logic [NUM_DESC-1:0]                 fill_v;
  logic                                fill;
  logic                                blocked;
  logic [RXR_DW-1:0]                   status_word;
  logic                                unused_wr_bits;

  assign unused_wr_bits = ^reg_wr_data[RXR_ALIGN-1:1];

  rxring_regif #(.NUM_DESC(NUM_DESC)) u_regif (
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_rd_addr (reg_rd_addr),
    .en_v        (ent_en),
    .done_v      (ent_done),
    .baddr_v     (ent_baddr),
    .status_v    (ent_status),
    .cur_idx     (cur_idx),
    .buf_we      (buf_we),
    .reg_rd_data (reg_rd_data)
  );

  assign blocked   = buf_we[cur_idx];
  assign cur_armed = ent_en[cur_idx];
  assign cur_buf   = ent_baddr[cur_idx];

  rxring_seq #(.NUM_DESC(NUM_DESC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fe_valid    (fe_valid),
    .fe_len      (fe_len),
    .fe_flags    (fe_flags),
    .blocked     (blocked),
    .cur_armed   (cur_armed),
    .fe_ready    (fe_ready),
    .fill        (fill),
    .cur_idx     (cur_idx),
    .status_word (status_word)
  );

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
    assign fill_v[i] = fill && (cur_idx == IDX_W'(i));
    rxring_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (buf_we[i]),
      .sw_addr   (reg_wr_data[RXR_DW-1:RXR_ALIGN]),
      .sw_en     (reg_wr_data[0]),
      .hw_fill   (fill_v[i]),
      .hw_status (status_word),
      .en        (ent_en[i]),
      .done      (ent_done[i]),
      .baddr     (ent_baddr[i]),
      .status    (ent_status[i])
    );
  end

  assign irq = |(ent_done & ~ent_en);
endmodule

// File: rtl/rx_desc_ring_chk.sv
`timescale 1ns/1ps
module rx_desc_ring_chk #(
  parameter int NUM_DESC = 4,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int RA_W  = IDX_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fe_valid,
  input logic                fe_ready,
  input logic                cur_armed,
  input logic [IDX_W-1:0]    cur_idx,
  input logic                irq,
  input logic                reg_wr_en,
  input logic [RA_W-1:0]     reg_wr_addr,
  input logic                wr_en_bit,
  input logic [NUM_DESC-1:0] en_v,
  input logic [NUM_DESC-1:0] done_v
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);

  // R5 R6
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && cur_armed) |=>
      (cur_idx == (($past(cur_idx) == LAST) ? '0 : $past(cur_idx) + IDX_W'(1))));

  // R5
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && cur_armed) |=>
      (done_v[$past(cur_idx)] && !en_v[$past(cur_idx)]));

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && !cur_armed) |=> $stable(cur_idx));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_ready) |=> $stable(cur_idx));

  // R3
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_addr[0] && wr_en_bit) |=>
      (en_v[$past(reg_wr_addr[RA_W-1:1])] && !done_v[$past(reg_wr_addr[RA_W-1:1])]));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && cur_armed) |=> irq);
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.NUM_DESC(NUM_DESC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fe_valid    (fe_valid),
  .fe_ready    (fe_ready),
  .cur_armed   (cur_armed),
  .cur_idx     (cur_idx),
  .irq         (irq),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .wr_en_bit   (reg_wr_data[0]),
  .en_v        (ent_en),
  .done_v      (ent_done)
);

// File: tb/rx_desc_ring_bench.sv
`timescale 1ns/1ps
module rx_desc_ring_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic [2:0]  reg_rd_addr;
  logic [31:0] reg_rd_data;
  logic        fe_valid;
  logic        fe_ready;
  logic [13:0] fe_len;
  logic [17:0] fe_flags;
  logic [1:0]  cur_idx;
  logic [25:0] cur_buf;
  logic        cur_armed;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_desc_ring u_rx_desc_ring (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fe_valid(fe_valid), .fe_ready(fe_ready), .fe_len(fe_len), .fe_flags(fe_flags),
    .cur_idx(cur_idx), .cur_buf(cur_buf), .cur_armed(cur_armed), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #0.2;
    d = reg_rd_data;
  endtask

  task automatic frame(input logic [13:0] len, input logic [17:0] fl);
    @(negedge clk);
    fe_valid = 1'b1; fe_len = len; fe_flags = fl;
    @(negedge clk);
    fe_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R1 reg zero", d, 32'h0);
    end
    chk("R1 idx", 32'(cur_idx), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ready", 32'(fe_ready), 1);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(3'd0, 32'h1000_0041);
    rd(3'd0, d); chk("R2 R3 arm slot0", d, 32'h1000_0041);
    chk("R10 cur_buf", 32'(cur_buf), 32'h0040_0001);
    chk("R10 cur_armed", 32'(cur_armed), 1);
    wr(3'd2, 32'h2000_0080);
    rd(3'd2, d); chk("R3 enable clear write", d, 32'h2000_0080);
    wr(3'd4, 32'h3000_00FF);
    rd(3'd4, d); chk("R2 low bits ignored", d, 32'h3000_00C1);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R4 status write ignored", d, 32'h0);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    wr(3'd2, 32'h2000_0081);
    wr(3'd6, 32'h4000_0001);
    frame(14'd100, 18'h5);
    rd(3'd1, d); chk("R5 status word", d, 32'h0001_4064);
    rd(3'd0, d); chk("R5 R2 slot0 done", d, 32'h1000_0046);
    chk("R5 idx", 32'(cur_idx), 1);
    chk("R8 irq up", 32'(irq), 1);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R4 status kept", d, 32'h0001_4064);
    wr(3'd0, 32'h1000_0041);
    chk("R8 irq down after rearm", 32'(irq), 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    frame(14'd60, 18'h0);
    frame(14'd70, 18'h4000);
    frame(14'd80, 18'h80);
    chk("R6 idx wrapped", 32'(cur_idx), 0);
    rd(3'd5, d); chk("R5 broadcast bit", d, 32'h1000_0046);
    rd(3'd7, d); chk("R5 crc bit", d, 32'h0020_0050);
    chk("R10 cur_armed slot0", 32'(cur_armed), 1);
    chk("R10 cur_buf slot0", 32'(cur_buf), 32'h0040_0001);
    frame(14'd90, 18'h0);
    chk("R6 idx after wrap", 32'(cur_idx), 1);
    rd(3'd1, d); chk("R6 slot0 refill", d, 32'h0000_005A);
  endtask

  task automatic t_miss();
    logic [31:0] d;
    chk("R10 disarmed", 32'(cur_armed), 0);
    frame(14'd200, 18'h0);
    chk("R7 idx held", 32'(cur_idx), 1);
    rd(3'd3, d); chk("R7 slot1 untouched", d, 32'h0000_003C);
    wr(3'd2, 32'h2000_0081);
    frame(14'd300, 18'h0);
    rd(3'd3, d); chk("R7 missed flag set", d, 32'h8000_012C);
    wr(3'd4, 32'h3000_0001);
    frame(14'd400, 18'h0);
    rd(3'd5, d); chk("R7 missed flag cleared", d, 32'h0000_0190);
    chk("R7 idx", 32'(cur_idx), 3);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 3'd6; reg_wr_data = 32'h4000_0001;
    fe_valid = 1'b1; fe_len = 14'd500; fe_flags = 18'h0;
    #0.2;
    chk("R9 ready low", 32'(fe_ready), 0);
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R9 frame held", 32'(cur_idx), 3);
    rd(3'd6, d); chk("R9 write applied", d, 32'h4000_000D);
    chk("R9 ready back", 32'(fe_ready), 1);
    @(negedge clk);
    fe_valid = 1'b0;
    chk("R9 idx after", 32'(cur_idx), 0);
    rd(3'd7, d); chk("R9 status", d, 32'h0000_01F4);
    chk("R8 irq pending", 32'(irq), 1);
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_addr = '0; fe_valid = 1'b0; fe_len = '0; fe_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_layout();
    t_status_ro();
    t_fill();
    t_wrap();
    t_miss();
    t_stall();
    t_rereset();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule